// File: doc/BRIEF.md
# Frame Timestamp Capture Latches

This block takes a snapshot of a free-running 64-bit nanosecond time value whenever a frame that needs a timestamp crosses the port. A separate time counter supplies that value. There are two capture paths.

The transmit path has a single latch. It can raise an interrupt when it captures. The receive path has a bank of four latches, called slots. Each received frame arrives with a classification from an upstream parser: event message or not, protocol version 1 or 2, and carried in UDP or directly at layer 2. A frame that passes the configured filter takes the lowest-numbered free slot. The block then reports that slot number to the receive datapath, so the descriptor can point software at the right stamp.

Software works through a small read port. Every latch holds its value until software reads the latch's high word, and that read frees it. Software reads the low word first, then the high word. A status word shows which latches are occupied. It also carries a sticky flag that records a receive frame which qualified while every slot was taken. Reading the status word and every high word, one read each, returns the whole block to empty.

Top module: `ts_capture_latches`

## Requirements
- R1: After reset every latch is empty, the status word reads 0, `tx_irq` is 0 and `rx_stamped` is 0.
- R2: A qualifying receive frame seen on a clock edge stores `time_ns` of that cycle into a free slot. One edge later, `rx_stamped` pulses for one cycle, `rx_slot` gives the slot number, and status bit i (i = slot number) is set.
- R3: A qualifying receive frame always takes the lowest-numbered free slot.
- R4: An occupied slot keeps its stamp. Later frames and reads of its low word neither overwrite it nor free it.
- R5: A read of a slot's high word frees that slot. Its status bit is 0 from the next edge on, and the slot can be reused.
- R6: With the version-1 filter selected (`cfg_ver2`=0), a frame is stamped only if it is a version-1 event frame carried in UDP and `cfg_udp_en`=1. With `cfg_udp_en`=0, no frame is stamped.
- R7: With the version-2 filter selected (`cfg_ver2`=1), a version-2 layer-2 event frame is stamped whatever `cfg_udp_en` is. A version-2 UDP event frame is stamped only with `cfg_udp_en`=1. A frame of the other version, a non-event frame, or any frame while `cfg_msg_en`=0 is never stamped.
- R8: A qualifying frame that arrives while all four slots are occupied is not stamped and does not change any slot. It sets the overflow flag (status bit 5). The flag stays set until a read of the status word, and that read returns it as 1 and clears it.
- R9: A transmit request with the transmit latch empty captures `time_ns` and sets status bit 4. While that bit is set, further transmit requests are ignored. A read of the transmit high word frees the latch.
- R10: A transmit capture made while `tx_irq_en`=1 drives `tx_irq` high from the next edge until the transmit high word is read. A capture made with `tx_irq_en`=0 never raises `tx_irq`.
- R11: Reading the status word and every high word leaves the block empty: the status word reads 0.
- R12: Read map (word address): 0 is status, with bits 3..0 for receive slots 0..3, bit 4 for the transmit latch and bit 5 for overflow. 1 and 2 are the transmit low and high words. 3+2i and 4+2i are the low and high words of receive slot i. Reads of low words have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_ns | input | 64 | Current time in nanoseconds from the time counter |
| cfg_ver2 | input | 1 | Receive filter version: 0 selects version 1, 1 selects version 2 |
| cfg_msg_en | input | 1 | Event-message recognition enable |
| cfg_udp_en | input | 1 | UDP recognition enable |
| rx_frame_valid | input | 1 | One-cycle strobe: a classified receive frame passes |
| rx_frame_v2 | input | 1 | The frame is version 2 (0 means version 1) |
| rx_frame_udp | input | 1 | The frame is carried in UDP (0 means layer 2) |
| rx_frame_event | input | 1 | The frame is an event message |
| rx_stamped | output | 1 | One-cycle pulse: the previous frame was stamped |
| rx_slot | output | 2 | Slot number holding the stamp, valid with `rx_stamped` |
| tx_frame_valid | input | 1 | One-cycle strobe: a transmit frame asks for a stamp |
| tx_irq_en | input | 1 | Transmit timestamp interrupt enable |
| tx_irq | output | 1 | Transmit timestamp interrupt |
| rd_en | input | 1 | Read strobe; side effects take place on this edge |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |

## Verification
Captures, `rx_stamped`, `rx_slot`, `tx_irq` and the overflow flag are all registered. Each is due exactly one rising edge after the cycle that carries the frame or transmit strobe. `rd_data` is combinational, so it is valid in the same cycle as the address. The release or clear that a read causes becomes visible one edge later.

The bench drives every stimulus on the falling edge and holds it across exactly one rising edge. It samples results on the following falling edge. A read therefore returns its data before its side effect, and a follow-up status read shows that side effect.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    // Classification of a received frame, supplied by an upstream parser.
    typedef struct packed {
        logic valid;
        logic is_v2;
        logic is_udp;
        logic is_event;
    } frame_class_t;

    // Receive filter configuration.
    typedef struct packed {
        logic ver2;
        logic msg_en;
        logic udp_en;
    } rx_cfg_t;

    // Kinds of read access on the software port.
    typedef enum logic [1:0] {
        RD_STATUS = 2'd0,
        RD_LOW    = 2'd1,
        RD_HIGH   = 2'd2,
        RD_NONE   = 2'd3
    } rd_kind_t;

    localparam int STATUS_ADDR = 0;
    localparam int TX_LO_ADDR  = 1;
    localparam int TX_HI_ADDR  = 2;
    localparam int RX_BASE     = 3;

    // Eligibility rule: the version must match the configured one; version 1
    // needs UDP transport, version 2 accepts layer 2 or UDP; UDP transport
    // needs UDP recognition enabled.
    function automatic logic frame_eligible(frame_class_t f, rx_cfg_t c);
        logic ver_ok;
        logic trn_ok;
        ver_ok = (f.is_v2 == c.ver2);
        if (f.is_udp)
            trn_ok = c.udp_en;
        else
            trn_ok = f.is_v2;
        return f.valid && f.is_event && c.msg_en && ver_ok && trn_ok;
    endfunction

endpackage

// File: rtl/ts_rx_filter.sv
module ts_rx_filter
    import ts_cap_pkg::*;
(
    input  frame_class_t frame,
    input  rx_cfg_t      cfg,
    output logic         qualify
);

    always_comb begin
        qualify = frame_eligible(frame, cfg);
    end

    // R6: a version-1 frame never qualifies without UDP transport and UDP recognition
    always_comb begin
        if (qualify && !frame.is_v2)
            a_r6_v1_needs_udp: assert (frame.is_udp && cfg.udp_en);
    end

endmodule

// File: rtl/ts_slot_bank.sv
module ts_slot_bank #(
    parameter int NUM_RX = 4,
    parameter int TIME_W = 64,
    localparam int IDX_W = (NUM_RX > 1) ? $clog2(NUM_RX) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          capture,
    input  logic [TIME_W-1:0]             time_in,
    input  logic [NUM_RX-1:0]             release_vec,
    output logic [NUM_RX-1:0]             valid_vec,
    output logic [NUM_RX-1:0][TIME_W-1:0] stamps,
    output logic                          stamped,
    output logic [IDX_W-1:0]              slot,
    output logic                          overflow_hit
);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    // Lowest free index wins: scan downward so the last hit is the lowest.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = NUM_RX - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign overflow_hit = capture && !free_found;

    generate
        for (genvar g = 0; g < NUM_RX; g++) begin : g_slot
            logic take;
            assign take = capture && free_found && (free_idx == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_vec[g] <= 1'b0;
                    stamps[g]    <= '0;
                end else if (take) begin
                    valid_vec[g] <= 1'b1;
                    stamps[g]    <= time_in;
                end else if (release_vec[g]) begin
                    valid_vec[g] <= 1'b0;
                end
            end

            // R4: an occupied slot without a release keeps its stamp
            a_r4_slot_holds: assert property (@(posedge clk) disable iff (rst)
                valid_vec[g] && !release_vec[g] |=> valid_vec[g] && $stable(stamps[g]));

            // R5: a release of an occupied slot empties it on the next edge
            a_r5_slot_frees: assert property (@(posedge clk) disable iff (rst)
                valid_vec[g] && release_vec[g] |=> !valid_vec[g]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stamped <= 1'b0;
            slot    <= '0;
        end else begin
            stamped <= capture && free_found;
            if (capture && free_found)
                slot <= free_idx;
        end
    end

    // R3: every slot below the chosen one was already occupied
    a_r3_lowest_free: assert property (@(posedge clk) disable iff (rst)
        stamped |-> ((~$past(valid_vec)) & NUM_RX'((1 << slot) - 1)) == '0);

    // R2: the reported slot now holds a stamp
    a_r2_slot_occupied: assert property (@(posedge clk) disable iff (rst)
        stamped |-> valid_vec[slot]);

endmodule

// File: rtl/ts_tx_latch.sv
module ts_tx_latch #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [TIME_W-1:0] time_in,
    input  logic              release_req,
    input  logic              irq_en,
    output logic              valid,
    output logic [TIME_W-1:0] stamp,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            stamp <= '0;
            irq   <= 1'b0;
        end else if (valid) begin
            if (release_req) begin
                valid <= 1'b0;
                irq   <= 1'b0;
            end
        end else if (capture) begin
            valid <= 1'b1;
            stamp <= time_in;
            irq   <= irq_en;
        end
    end

    // R9: a held stamp is not replaced while the latch is occupied
    a_r9_tx_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        valid && !release_req |=> valid && $stable(stamp));

    // R10: the interrupt is only ever raised with a stamp held
    a_r10_irq_needs_stamp: assert property (@(posedge clk) disable iff (rst)
        irq |-> valid);

    // R10: a release drops the interrupt
    a_r10_irq_clears: assert property (@(posedge clk) disable iff (rst)
        valid && release_req |=> !irq);

endmodule

// File: rtl/ts_capture_latches.sv
module ts_capture_latches
    import ts_cap_pkg::*;
#(
    parameter int NUM_RX = 4,
    parameter int TIME_W = 64,
    parameter int WORD_W = 32,
    localparam int IDX_W  = (NUM_RX > 1) ? $clog2(NUM_RX) : 1,
    localparam int N_ADDR = RX_BASE + 2 * NUM_RX,
    localparam int ADDR_W = $clog2(N_ADDR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] time_ns,
    input  logic              cfg_ver2,
    input  logic              cfg_msg_en,
    input  logic              cfg_udp_en,
    input  logic              rx_frame_valid,
    input  logic              rx_frame_v2,
    input  logic              rx_frame_udp,
    input  logic              rx_frame_event,
    output logic              rx_stamped,
    output logic [IDX_W-1:0]  rx_slot,
    input  logic              tx_frame_valid,
    input  logic              tx_irq_en,
    output logic              tx_irq,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    frame_class_t                  frame;
    rx_cfg_t                       cfg;
    logic                          rx_qualify;
    logic [NUM_RX-1:0]             rx_valid;
    logic [NUM_RX-1:0][TIME_W-1:0] rx_stamps;
    logic [NUM_RX-1:0]             rx_release;
    logic                          ovf_hit;
    logic                          ovf_q;
    logic                          tx_valid;
    logic [TIME_W-1:0]             tx_stamp;
    logic                          tx_release;
    rd_kind_t                      rd_kind;

    assign frame = '{valid: rx_frame_valid, is_v2: rx_frame_v2,
                     is_udp: rx_frame_udp, is_event: rx_frame_event};
    assign cfg   = '{ver2: cfg_ver2, msg_en: cfg_msg_en, udp_en: cfg_udp_en};

    ts_rx_filter u_filter (
        .frame   (frame),
        .cfg     (cfg),
        .qualify (rx_qualify)
    );

    ts_slot_bank #(
        .NUM_RX (NUM_RX),
        .TIME_W (TIME_W)
    ) u_slots (
        .clk          (clk),
        .rst          (rst),
        .capture      (rx_qualify),
        .time_in      (time_ns),
        .release_vec  (rx_release),
        .valid_vec    (rx_valid),
        .stamps       (rx_stamps),
        .stamped      (rx_stamped),
        .slot         (rx_slot),
        .overflow_hit (ovf_hit)
    );

    ts_tx_latch #(
        .TIME_W (TIME_W)
    ) u_tx (
        .clk         (clk),
        .rst         (rst),
        .capture     (tx_frame_valid),
        .time_in     (time_ns),
        .release_req (tx_release),
        .irq_en      (tx_irq_en),
        .valid       (tx_valid),
        .stamp       (tx_stamp),
        .irq         (tx_irq)
    );

    // Read decode: data is combinational, side effects are gated by rd_en.
    always_comb begin
        rd_data    = '0;
        rd_kind    = RD_NONE;
        rx_release = '0;
        if (rd_addr == ADDR_W'(STATUS_ADDR)) begin
            rd_kind = RD_STATUS;
            rd_data = WORD_W'({ovf_q, tx_valid, rx_valid});
        end
        if (rd_addr == ADDR_W'(TX_LO_ADDR)) begin
            rd_kind = RD_LOW;
            rd_data = tx_stamp[WORD_W-1:0];
        end
        if (rd_addr == ADDR_W'(TX_HI_ADDR)) begin
            rd_kind = RD_HIGH;
            rd_data = WORD_W'(tx_stamp[TIME_W-1:WORD_W]);
        end
        for (int i = 0; i < NUM_RX; i++) begin
            if (rd_addr == ADDR_W'(RX_BASE + 2 * i)) begin
                rd_kind = RD_LOW;
                rd_data = rx_stamps[i][WORD_W-1:0];
            end
            if (rd_addr == ADDR_W'(RX_BASE + 2 * i + 1)) begin
                rd_kind       = RD_HIGH;
                rd_data       = WORD_W'(rx_stamps[i][TIME_W-1:WORD_W]);
                rx_release[i] = rd_en;
            end
        end
    end

    assign tx_release = rd_en && (rd_addr == ADDR_W'(TX_HI_ADDR));

    // Sticky overflow: a new hit takes priority over a clearing status read.
    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (ovf_hit)
            ovf_q <= 1'b1;
        else if (rd_en && rd_kind == RD_STATUS)
            ovf_q <= 1'b0;
    end

    // R8: a qualifying frame with every slot occupied is flagged, not stamped
    a_r8_overflow_flag: assert property (@(posedge clk) disable iff (rst)
        rx_qualify && (&rx_valid) |=> ovf_q && !rx_stamped);

    // R12: a low-word read never frees anything
    a_r12_low_read_no_effect: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_kind == RD_LOW && !rx_qualify && !tx_frame_valid
        |=> rx_valid == $past(rx_valid) && tx_valid == $past(tx_valid));

endmodule

// File: tb/tb_ts_capture_latches.sv
`timescale 1ns/1ps
module tb_ts_capture_latches;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_ns = '0;
    logic        cfg_ver2 = 1'b1, cfg_msg_en = 1'b1, cfg_udp_en = 1'b1;
    logic        rx_frame_valid = 1'b0, rx_frame_v2 = 1'b0, rx_frame_udp = 1'b0, rx_frame_event = 1'b0;
    logic        rx_stamped;
    logic [1:0]  rx_slot;
    logic        tx_frame_valid = 1'b0, tx_irq_en = 1'b0, tx_irq;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ts_capture_latches dut (
        .clk(clk), .rst(rst), .time_ns(time_ns),
        .cfg_ver2(cfg_ver2), .cfg_msg_en(cfg_msg_en), .cfg_udp_en(cfg_udp_en),
        .rx_frame_valid(rx_frame_valid), .rx_frame_v2(rx_frame_v2),
        .rx_frame_udp(rx_frame_udp), .rx_frame_event(rx_frame_event),
        .rx_stamped(rx_stamped), .rx_slot(rx_slot),
        .tx_frame_valid(tx_frame_valid), .tx_irq_en(tx_irq_en), .tx_irq(tx_irq),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_stamp(input logic [3:0] lo_a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(lo_a, lo);
        rd(lo_a + 4'd1, hi);
        v = {hi, lo};
    endtask

    // Drives one receive frame, then samples the registered result one edge later.
    task automatic rx_frame(input logic v2, input logic udp, input logic ev,
                            input logic [63:0] t, output logic st, output logic [1:0] sl);
        @(negedge clk);
        time_ns = t; rx_frame_valid = 1'b1; rx_frame_v2 = v2;
        rx_frame_udp = udp; rx_frame_event = ev;
        @(negedge clk);
        rx_frame_valid = 1'b0;
        st = rx_stamped; sl = rx_slot;
    endtask

    task automatic tx_frame(input logic [63:0] t);
        @(negedge clk);
        time_ns = t; tx_frame_valid = 1'b1;
        @(negedge clk);
        tx_frame_valid = 1'b0;
    endtask

    task automatic bulk_clear();
        logic [31:0] d;
        rd(4'd0, d);
        rd(4'd2, d);
        for (int i = 0; i < 4; i++) rd(4'(4 + 2 * i), d);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 stamped after reset", 64'(rx_stamped), 64'd0);
        check("R1 irq after reset", 64'(tx_irq), 64'd0);
        rd(4'd0, d);
        check("R1 status after reset", 64'(d), 64'd0);
    endtask

    task automatic t_rx_basic();
        logic st; logic [1:0] sl; logic [31:0] d; logic [63:0] v;
        cfg_ver2 = 1'b1; cfg_msg_en = 1'b1; cfg_udp_en = 1'b1;
        rx_frame(1, 0, 1, 64'h1234_5678_9abc_def0, st, sl);
        check("R2 stamped pulse", 64'(st), 64'd1);
        check("R2 slot number", 64'(sl), 64'd0);
        @(negedge clk);
        check("R2 stamped is one cycle", 64'(rx_stamped), 64'd0);
        rd(4'd0, d);
        check("R2 status bit", 64'(d), 64'h01);
        rx_frame(1, 1, 1, 64'h0000_0001_0000_0002, st, sl);
        check("R3 second frame slot", 64'(sl), 64'd1);
        rd(4'd3, d);
        check("R12 slot0 low word", 64'(d), 64'h9abc_def0);
        rd(4'd0, d);
        check("R4 low read keeps slot", 64'(d), 64'h03);
        rd(4'd4, d);
        check("R12 slot0 high word", 64'(d), 64'h1234_5678);
        rd(4'd0, d);
        check("R5 high read frees slot0", 64'(d), 64'h02);
        rx_frame(1, 0, 1, 64'hAAAA_0000_BBBB_0000, st, sl);
        check("R3 reuse lowest free", 64'(sl), 64'd0);
        rx_frame(1, 0, 1, 64'hCCCC_0000_DDDD_0000, st, sl);
        check("R3 next free is slot2", 64'(sl), 64'd2);
        rd_stamp(4'd5, v);
        check("R4 slot1 unchanged", v, 64'h0000_0001_0000_0002);
        rd_stamp(4'd3, v);
        check("R5 reused slot0 value", v, 64'hAAAA_0000_BBBB_0000);
        bulk_clear();
        rd(4'd0, d);
        check("R11 bulk clear empties", 64'(d), 64'd0);
    endtask

    task automatic t_filter();
        logic st; logic [1:0] sl; logic [31:0] d;
        cfg_ver2 = 1'b0; cfg_udp_en = 1'b0; cfg_msg_en = 1'b1;
        rx_frame(0, 1, 1, 64'd10, st, sl);
        check("R6 v1 udp with udp off", 64'(st), 64'd0);
        rx_frame(0, 0, 1, 64'd11, st, sl);
        check("R6 v1 l2 with udp off", 64'(st), 64'd0);
        cfg_udp_en = 1'b1;
        rx_frame(0, 1, 1, 64'd12, st, sl);
        check("R6 v1 udp with udp on", 64'(st), 64'd1);
        rx_frame(0, 0, 1, 64'd13, st, sl);
        check("R6 v1 l2 rejected", 64'(st), 64'd0);
        cfg_ver2 = 1'b1; cfg_udp_en = 1'b0;
        rx_frame(1, 0, 1, 64'd14, st, sl);
        check("R7 v2 l2 with udp off", 64'(st), 64'd1);
        rx_frame(1, 1, 1, 64'd15, st, sl);
        check("R7 v2 udp with udp off", 64'(st), 64'd0);
        rx_frame(0, 1, 1, 64'd16, st, sl);
        check("R7 version mismatch", 64'(st), 64'd0);
        rx_frame(1, 0, 0, 64'd17, st, sl);
        check("R7 non-event", 64'(st), 64'd0);
        cfg_msg_en = 1'b0;
        rx_frame(1, 0, 1, 64'd18, st, sl);
        check("R7 message enable off", 64'(st), 64'd0);
        cfg_msg_en = 1'b1; cfg_udp_en = 1'b1;
        rd(4'd0, d);
        check("R7 two slots taken", 64'(d), 64'h03);
        bulk_clear();
    endtask

    task automatic t_overflow();
        logic st; logic [1:0] sl; logic [31:0] d; logic [63:0] v;
        for (int i = 0; i < 4; i++) rx_frame(1, 0, 1, 64'(100 + i), st, sl);
        check("R3 fourth slot", 64'(sl), 64'd3);
        rx_frame(1, 0, 1, 64'd999, st, sl);
        check("R8 not stamped when full", 64'(st), 64'd0);
        rd(4'd0, d);
        check("R8 overflow flag set", 64'(d), 64'h2F);
        rd(4'd0, d);
        check("R8 flag cleared by status read", 64'(d), 64'h0F);
        rd_stamp(4'd9, v);
        check("R8 slot3 not overwritten", v, 64'd103);
        bulk_clear();
        rd(4'd0, d);
        check("R11 empty after full bank", 64'(d), 64'd0);
    endtask

    task automatic t_tx();
        logic [31:0] d; logic [63:0] v;
        tx_irq_en = 1'b0;
        tx_frame(64'h0000_0042_0000_0777);
        check("R10 no irq when disabled", 64'(tx_irq), 64'd0);
        rd(4'd0, d);
        check("R9 tx status bit", 64'(d), 64'h10);
        tx_frame(64'hFFFF_FFFF_FFFF_FFFF);
        rd_stamp(4'd1, v);
        check("R9 busy latch kept first stamp", v, 64'h0000_0042_0000_0777);
        rd(4'd0, d);
        check("R9 high read frees tx", 64'(d), 64'h00);
        tx_irq_en = 1'b1;
        tx_frame(64'h5);
        check("R10 irq one edge after capture", 64'(tx_irq), 64'd1);
        rd(4'd1, d);
        check("R10 irq held over low read", 64'(tx_irq), 64'd1);
        rd(4'd2, d);
        check("R10 irq cleared by high read", 64'(tx_irq), 64'd0);
        tx_irq_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_rx_basic();
        t_filter();
        t_overflow();
        t_tx();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule